// File: doc/BRIEF.md
# Display Register Serial Master

This block gives a host a plain request port for reading and writing the 16-bit registers of a display driver chip over a four-wire serial link. The wires are an active-low chip select, a serial clock, a data output line and a data input line. The host presents a register number, a write value and a direction flag with a valid/ready handshake. The block then runs two serial frames on its own and reports completion on a one-cycle response strobe that carries the read value.

Each frame is 24 bits long. Its top byte is a header: a device identifier, set by a parameter, combined by OR with a 2-bit operation code. The low 16 bits carry a register number, a write value or, on a read, nothing. The first frame of every access names the register. The second frame either delivers the value or fetches it. Bit timing comes from a divider of the system clock. Each half of a serial bit lasts `HALF_DIV` system clocks. Chip select opens and closes one half period away from the outer clock edges.

Top module: `dspi_reg_master`

## Requirements
- R1: Every frame carries exactly 24 clock pulses. Bits leave most significant first, so frame bit 23 is the first bit on `spi_mosi`.
- R2: Frame bits 23..16 equal `DEV_ID | op`, where `op` is 0 for the register-number frame, 1 for status read, 2 for data write and 3 for data read. The register-number frame holds `req_addr` in bits 15..0.
- R3: A write access sends the register-number frame and then a data-write frame (op 2) with `req_wdata` in bits 15..0.
- R4: A read access sends the register-number frame and then a data-read frame (op 3) with bits 15..0 at zero. `rsp_rdata` returns the last 16 bits shifted in during that second frame, and `rsp_valid` is high for a single cycle.
- R5: Each frame has its own select pulse. Select stays high for at least one half period between two frames.
- R6: Within a bit, `spi_sck` falls and `spi_mosi` changes in the same cycle. `spi_miso` is sampled at the end of the low half, and then the clock is high for a half period. Each half lasts `HALF_DIV` system clocks, with a minimum of 2.
- R7: Out of reset and while idle, `spi_cs_n`, `spi_sck` and `spi_mosi` are all high, `busy` is low and `req_ready` is high.
- R8: The time from select falling to the first clock fall is at least one half period. The time from the last clock rise to select rising is also at least one half period.
- R9: `busy` is high from acceptance until the response. `req_ready` is low during that time, and a request presented while busy starts no frame and changes no response.
- R10: A write access also ends with a one-cycle `rsp_valid`, with `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | REG_W | Register number |
| req_wdata | input | REG_W | Value to write |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | REG_W | Read result (zero for writes) |
| busy | output | 1 | Access in progress |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the display chip |
| spi_miso | input | 1 | Serial data from the display chip |

## Verification
A wrong bit counter or shift register appears at the pins within the affected frame. The frame shows up with a clock count other than 24, a corrupted header byte, or a data frame that does not match the one the scoreboard queued. A wrong sample point or a wrong receive shift shows only at the end of the second frame, when `rsp_rdata` differs from the value the serial model sent. A sequencer that leaves its idle state wrongly, or accepts requests while busy, produces extra frames or extra responses at once, and these are left over or missing in the expected queues.

// File: rtl/dspi_pkg.sv
// Shared definitions for the display register serial master.
// Assumes an 8-bit frame header whose low two bits encode the operation.
package dspi_pkg;

    localparam int HDR_W = 8;

    typedef enum logic [1:0] {
        OP_IDX_WR  = 2'd0,
        OP_STAT_RD = 2'd1,
        OP_DAT_WR  = 2'd2,
        OP_DAT_RD  = 2'd3
    } dspi_op_e;

    // Header byte: device identifier with the operation code merged in.
    function automatic logic [HDR_W-1:0] make_hdr(input logic [HDR_W-1:0] id,
                                                  input dspi_op_e op);
        return id | {{(HDR_W-2){1'b0}}, op};
    endfunction

endpackage

// File: rtl/dspi_halfbit_timer.sv
// Half-bit timer: while run is high, pulses tick once every HALF_DIV
// system clocks, the first pulse HALF_DIV cycles after run rises.
// Assumes HALF_DIV >= 2. The count restarts whenever run is low.
module dspi_halfbit_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the half-period counter never passes its terminal value
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/dspi_frame_engine.sv
// Frame engine: shifts one FB-bit frame out MSB first and collects the
// last RX_W received bits. Select falls on start, then for each bit the
// clock falls with new data, the input is sampled a half period later and
// the clock rises. Select rises a half period after the last rise, and a
// half-period gap follows before done. A new start is taken in the last
// gap cycle, so frames can run back to back.
module dspi_frame_engine #(
    parameter int FB       = 24,
    parameter int RX_W     = 16,
    parameter int HALF_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FB-1:0] frame,
    output logic          fr_busy,
    output logic          done,
    output logic [RX_W-1:0] rx,
    output logic          cs_n,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    localparam int BW = $clog2(FB);
    localparam logic [BW-1:0] LASTBIT = BW'(FB - 1);

    typedef enum logic [2:0] {F_IDLE, F_SETUP, F_LOW, F_HIGH, F_HOLD, F_GAP} fstate_e;

    fstate_e         st;
    logic [FB-1:0]   shreg;
    logic [RX_W-1:0] rxreg;
    logic [BW-1:0]   bitcnt;
    logic            tick;
    logic            accept;

    dspi_halfbit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st != F_IDLE),
        .tick (tick)
    );

    assign accept  = start && ((st == F_IDLE) || (st == F_GAP && tick));
    assign done    = (st == F_GAP) && tick;
    assign fr_busy = (st != F_IDLE);
    assign rx      = rxreg;

    // Frame state machine driving select, clock and data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= F_IDLE;
            cs_n   <= 1'b1;
            sck    <= 1'b1;
            mosi   <= 1'b1;
            shreg  <= '0;
            rxreg  <= '0;
            bitcnt <= '0;
        end else if (accept) begin
            st     <= F_SETUP;
            cs_n   <= 1'b0;
            shreg  <= frame;
            bitcnt <= '0;
        end else if (tick) begin
            case (st)
                F_SETUP: begin
                    sck  <= 1'b0;
                    mosi <= shreg[FB-1];
                    st   <= F_LOW;
                end
                F_LOW: begin
                    rxreg <= {rxreg[RX_W-2:0], miso};
                    sck   <= 1'b1;
                    st    <= F_HIGH;
                end
                F_HIGH: begin
                    if (bitcnt == LASTBIT) begin
                        st <= F_HOLD;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        shreg  <= shreg << 1;
                        sck    <= 1'b0;
                        mosi   <= shreg[FB-2];
                        st     <= F_LOW;
                    end
                end
                F_HOLD: begin
                    cs_n <= 1'b1;
                    mosi <= 1'b1;
                    st   <= F_GAP;
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // R7: idle lines are all high
    a_r7_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == F_IDLE) |-> (cs_n && sck && mosi));

    // R1: bit counter stays inside one frame
    a_r1_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= LASTBIT);

    // R5: the clock can only be low inside a select pulse
    a_r5_sck_low_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sck);

    // R6: clock edges follow half-period ticks
    a_r6_sck_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> $past(tick));

    // R8: select rises only while the clock is high
    a_r8_cs_rise_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> sck);

endmodule

// File: rtl/dspi_reg_master.sv
// Display register serial master (top). Takes one register request at a
// time and runs two frames: a register-number frame, then a data-write or
// data-read frame. Ends with a one-cycle response strobe.
// Assumes the host holds request fields stable while req_valid is high.
module dspi_reg_master #(
    parameter logic [7:0] DEV_ID   = 8'h70,
    parameter int         HALF_DIV = 4,
    parameter int         REG_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [REG_W-1:0] req_addr,
    input  logic [REG_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata,
    output logic             busy,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    import dspi_pkg::*;

    localparam int FRAME_BITS = HDR_W + REG_W;

    typedef enum logic [1:0] {S_IDLE, S_INDEX, S_DATA} sstate_e;

    sstate_e                st;
    logic                   wr_q;
    logic [REG_W-1:0]       wdata_q;
    logic [FRAME_BITS-1:0]  fr_word;
    logic                   fr_start;
    logic                   fr_done;
    logic                   fr_busy;
    logic [REG_W-1:0]       fr_rx;
    logic                   accept_req;

    assign req_ready  = (st == S_IDLE);
    assign busy       = (st != S_IDLE);
    assign accept_req = req_valid && req_ready;
    assign fr_start   = accept_req || (st == S_INDEX && fr_done);

    // Pick the frame to launch: register number from the port, else data.
    always_comb begin
        if (st == S_IDLE) begin
            fr_word = {make_hdr(DEV_ID, OP_IDX_WR), req_addr};
        end else if (wr_q) begin
            fr_word = {make_hdr(DEV_ID, OP_DAT_WR), wdata_q};
        end else begin
            fr_word = {make_hdr(DEV_ID, OP_DAT_RD), {REG_W{1'b0}}};
        end
    end

    dspi_frame_engine #(
        .FB      (FRAME_BITS),
        .RX_W    (REG_W),
        .HALF_DIV(HALF_DIV)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fr_start),
        .frame  (fr_word),
        .fr_busy(fr_busy),
        .done   (fr_done),
        .rx     (fr_rx),
        .cs_n   (spi_cs_n),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .miso   (spi_miso)
    );

    // Access sequencer: register-number frame, data frame, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            wr_q      <= 1'b0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (accept_req) begin
                        wr_q    <= req_write;
                        wdata_q <= req_wdata;
                        st      <= S_INDEX;
                    end
                end
                S_INDEX: begin
                    if (fr_done) st <= S_DATA;
                end
                default: begin
                    if (fr_done) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= wr_q ? '0 : fr_rx;
                        st        <= S_IDLE;
                    end
                end
            endcase
        end
    end

    // R4: the response strobe lasts one cycle
    a_r4_rsp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: the serial engine never runs outside a busy access
    a_r9_frames_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fr_busy |-> busy);

    // R3: the data frame opens right after the register-number frame
    a_r3_data_follows_index: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_INDEX && fr_done) |=> (fr_busy && !spi_cs_n));

    // R10: a write response has zero data
    a_r10_write_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DATA && fr_done && wr_q) |=> (rsp_rdata == '0));

endmodule

// File: tb/dspi_reg_master_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected frames and responses, a
// serial slave model captures frames, and monitors compare them.
module dspi_reg_master_tb;
    localparam int H = 3;
    localparam logic [7:0] ID = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        busy;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [23:0] exp_frames[$];
    logic [15:0] exp_rsp[$];

    always #2.5 clk = ~clk;

    dspi_reg_master #(.DEV_ID(ID), .HALF_DIV(H), .REG_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc++;

    // Serial slave model state
    logic [23:0] cap = '0;
    logic [23:0] tx_word = '0;
    logic [15:0] last_idx = '0;
    int  nbits = 0, ntx = 0;
    int  cs_fall_cyc = 0, cs_rise_cyc = 0, fall_cyc = 0, rise_cyc = 0;
    bit  active = 0, seen_rise = 0, timing_ok = 1;

    // Frame start: load reply word and check the gap since the last frame.
    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            if (seen_rise)
                check((cyc - cs_rise_cyc) >= H, "R5", "select gap cycles",
                      cyc - cs_rise_cyc, H);
            active = 1; nbits = 0; ntx = 0; timing_ok = 1;
            cs_fall_cyc = cyc;
            tx_word = {8'h00, last_idx ^ 16'hA5C3};
        end
    end

    // Clock fall: present the next reply bit, check setup and high time.
    always @(negedge spi_sck) begin
        if (active) begin
            if (ntx == 0) begin
                check((cyc - cs_fall_cyc) >= H, "R8", "setup cycles",
                      cyc - cs_fall_cyc, H);
            end else if ((cyc - rise_cyc) != H) begin
                timing_ok = 0;
            end
            fall_cyc = cyc;
            spi_miso = (ntx < 24) ? tx_word[23 - ntx] : 1'b1;
            ntx++;
        end
    end

    // Clock rise: capture data out and check low time.
    always @(posedge spi_sck) begin
        if (active && !spi_cs_n) begin
            if ((cyc - fall_cyc) != H) timing_ok = 0;
            cap = {cap[22:0], spi_mosi};
            nbits++;
            rise_cyc = cyc;
        end
    end

    // Frame end: compare with the scoreboard.
    always @(posedge spi_cs_n) begin
        if (active) begin
            active = 0;
            seen_rise = 1;
            cs_rise_cyc = cyc;
            spi_miso = 1'b1;
            check(nbits == 24, "R1", "clocks per frame", nbits, 24);
            check((cyc - rise_cyc) >= H, "R8", "hold cycles", cyc - rise_cyc, H);
            check(timing_ok, "R6", "half-period timing", timing_ok, 1);
            if (exp_frames.size() == 0) begin
                check(0, "R9", "unexpected frame", cap, 0);
            end else begin
                logic [23:0] e;
                e = exp_frames.pop_front();
                check(cap == e, (e[17:16] == 2'd0) ? "R2" : "R3", "frame", cap, e);
            end
            if (cap[23:16] == ID) last_idx = cap[15:0];
        end
    end

    // Response monitor.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_rsp.size() == 0) begin
                check(0, "R9", "unexpected response", rsp_rdata, 0);
            end else begin
                logic [15:0] e;
                e = exp_rsp.pop_front();
                check(rsp_rdata == e, (e == 16'h0) ? "R10" : "R4", "response", rsp_rdata, e);
            end
        end
    end

    // Driver: queue expectations, issue one request, wait for its response.
    task automatic access(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                          input bit poke_busy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_frames.push_back({ID, addr});
        exp_frames.push_back({ID | (wr ? 8'h02 : 8'h03), wr ? wd : 16'h0000});
        exp_rsp.push_back(wr ? 16'h0000 : (addr ^ 16'hA5C3));
        req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        check(busy == 1'b1, "R9", "busy after accept", busy, 1);
        if (poke_busy) begin
            bit rdy_seen;
            rdy_seen = 0;
            req_valid = 1; req_write = 1; req_addr = 16'hDEAD; req_wdata = 16'hBEEF;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (req_ready) rdy_seen = 1;
            end
            req_valid = 0;
            check(!rdy_seen, "R9", "ready while busy", rdy_seen, 0);
        end
        while (!rsp_valid) @(negedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R4", "strobe width", rsp_valid, 0);
        check(busy == 1'b0 && req_ready == 1'b1, "R7", "idle after access",
              {busy, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check({spi_cs_n, spi_sck, spi_mosi} == 3'b111, "R7", "idle lines",
              {spi_cs_n, spi_sck, spi_mosi}, 3'b111);
        check(!busy && req_ready && !rsp_valid, "R7", "idle handshake",
              {busy, req_ready, rsp_valid}, 3'b010);

        access(1, 16'h0007, 16'h0000, 0);   // R3
        access(1, 16'h0046, 16'hEF00, 0);   // R3
        access(0, 16'h0000, 16'h0000, 0);   // R4
        access(0, 16'h00FF, 16'h0000, 1);   // R4, R9
        access(1, 16'hFFFF, 16'hFFFF, 0);   // R3, R10
        access(0, 16'hFFFF, 16'h0000, 0);   // R4
        access(0, 16'h1234, 16'h0000, 1);   // R9

        repeat (4 * H) @(negedge clk);
        check(exp_frames.size() == 0, "R9", "frames left", exp_frames.size(), 0);
        check(exp_rsp.size() == 0, "R9", "responses left", exp_rsp.size(), 0);
        check({spi_cs_n, spi_sck, spi_mosi} == 3'b111, "R7", "lines after run",
              {spi_cs_n, spi_sck, spi_mosi}, 3'b111);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule